// File: doc/BRIEF.md
# Memory Access Error and Bank Activity Monitor

This block sits next to a memory interface and watches every bus access presented to it: the address, whether it is a read or a write, and whether the addressed bank holds a device. From this stream it keeps sticky error flags and a per-bank record of which banks were written and which were read since the last refresh. Software sees two 32-bit registers through a small read/write port: an error register and a bank status register.

A write of any value to a register clears the state it reports. The bank activity bits are also wiped by a one-cycle refresh pulse from the memory controller. A read that falls in a fixed address window raises an over-range flag, whether or not a bank answers there. The memory protocol itself, refresh scheduling and bank mapping setup are handled elsewhere. The block only needs the access strobe, the bank-present mask and the refresh pulse.

Top module: `memErrBankMon`

## Requirements
- R1: Register select 0 reads the error register: bit 0 no-acknowledge flag, bit 1 acknowledge-error flag, bit 2 over-range flag, bits 15:8 the delay byte, all other bits zero. Read data is combinational and shows the current register contents in the same cycle.
- R2: A read access (accValid=1, accWrite=0) whose address lies between 0x0080_0000 and 0x03EF_FFFF inclusive sets the over-range flag, even when the bank there is present. Write accesses and addresses outside that window do not set it.
- R3: Any access, read or write, whose bank index (address bits 22:20) has a 0 in bankPresent sets the no-acknowledge flag.
- R4: A one-cycle pulse on ackErrPulse sets the acknowledge-error flag.
- R5: A register write (regWrEn=1) with select 0 clears all three error flags whatever the data is, and loads the delay byte from regWrData[15:8].
- R6: Register select 1 reads the bank status register: bits 15:8 hold one written bit per bank, bits 7:0 hold one read bit per bank, bit n belongs to bank n, and bits 31:16 are zero.
- R7: A write access to a present bank sets that bank's written bit, and a read access to a present bank sets its read bit. An access to an absent bank sets neither.
- R8: A refreshPulse clears all written and read bits and leaves the error register unchanged.
- R9: A register write with select 1 clears all written and read bits whatever the data is, and leaves the error register, including the delay byte, unchanged.
- R10: Error flags are sticky. Once set, a flag stays set until a clearing write, and several flags can be set together.
- R11: When an event and a clear of the same register arrive in the same cycle, the clear wins. Error events are dropped on an error-register write. Bank activity is dropped on a refresh or a bank-status write. A clear of one register does not block events aimed at the other.
- R12: After reset, both registers read as zero, including the delay byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | An access is presented this cycle |
| accWrite | input | 1 | 1 for a write access, 0 for a read |
| accAddr | input | 32 | Byte address of the access |
| bankPresent | input | 8 | Bit n high when bank n holds a device |
| ackErrPulse | input | 1 | Acknowledge-error event |
| refreshPulse | input | 1 | Refresh cycle done, clears bank activity |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 error register, 1 bank status register |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Contents of the selected register |

## Verification
The bench reads at both ends of the over-range window and just outside it, so an off-by-one compare shows up as a missing or stray flag. It also does a write inside the window, which must stay silent. It reads from a bank that is absent but inside the window. A design that gates the over-range flag on presence, or that updates bank bits for absent banks, fails there. It issues events in the same cycle as a clear of the same register and of the other register. A design with the wrong priority keeps a flag it should drop, or drops a bank bit it should keep. It also checks that the delay byte survives a bank clear and a refresh, and is reloaded on every error-register write.

// File: rtl/memMonPkg.sv
package memMonPkg;
  localparam int ADDR_W     = 32;
  localparam int DATA_W     = 32;
  localparam int NUM_BANKS  = 8;
  localparam int BANK_LSB   = 20;
  localparam int BANK_IDX_W = $clog2(NUM_BANKS);
  localparam int DELAY_W    = 8;
  localparam int DELAY_LSB  = 8;
  localparam int FLAG_W     = 3;
  localparam int FLAG_NACK  = 0;
  localparam int FLAG_ACK   = 1;
  localparam int FLAG_OVR   = 2;
  localparam logic [ADDR_W-1:0] OVR_LO = 32'h0080_0000;
  localparam logic [ADDR_W-1:0] OVR_HI = 32'h03EF_FFFF;
  localparam logic SEL_ERR  = 1'b0;
  localparam logic SEL_BANK = 1'b1;

  typedef struct packed {
    logic                 clrErr;
    logic                 clrBank;
    logic                 ldDelay;
    logic [FLAG_W-1:0]    setFlag;
    logic [NUM_BANKS-1:0] setDirty;
    logic [NUM_BANKS-1:0] setAcc;
  } monStrobe_t;
endpackage

// File: rtl/memMonCtrl.sv
module memMonCtrl
  import memMonPkg::*;
(
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [NUM_BANKS-1:0] bankPresent,
  input  logic                 ackErrPulse,
  input  logic                 refreshPulse,
  input  logic                 regWrEn,
  input  logic                 regSel,
  output monStrobe_t           strobe
);
  logic [BANK_IDX_W-1:0] bankIdx;
  logic                  bankHit;
  logic                  inWindow;
  logic                  errClr;
  logic                  bankClr;
  logic [NUM_BANKS-1:0]  bankOneHot;

  assign bankIdx  = accAddr[BANK_LSB +: BANK_IDX_W];
  assign bankHit  = bankPresent[bankIdx];
  assign inWindow = (accAddr >= OVR_LO) && (accAddr <= OVR_HI);
  assign errClr   = regWrEn && (regSel == SEL_ERR);
  assign bankClr  = refreshPulse || (regWrEn && (regSel == SEL_BANK));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bankDec
    assign bankOneHot[b] = accValid && bankHit && (bankIdx == BANK_IDX_W'(b));
  end

  always_comb begin
    strobe          = '0;
    strobe.clrErr   = errClr;
    strobe.clrBank  = bankClr;
    strobe.ldDelay  = errClr;
    if (!errClr) begin
      strobe.setFlag[FLAG_OVR]  = accValid && !accWrite && inWindow;
      strobe.setFlag[FLAG_NACK] = accValid && !bankHit;
      strobe.setFlag[FLAG_ACK]  = ackErrPulse;
    end
    if (!bankClr) begin
      strobe.setDirty = accWrite ? bankOneHot : '0;
      strobe.setAcc   = accWrite ? '0 : bankOneHot;
    end
  end
endmodule

// File: rtl/memMonDatapath.sv
module memMonDatapath
  import memMonPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  monStrobe_t           strobe,
  input  logic                 regSel,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  output logic [FLAG_W-1:0]    errFlags,
  output logic [NUM_BANKS-1:0] dirtyBits,
  output logic [NUM_BANKS-1:0] accBits
);
  logic [DELAY_W-1:0] delayByte;
  logic               unusedWrBits;

  assign unusedWrBits = ^{regWrData[DATA_W-1:DELAY_LSB+DELAY_W], regWrData[DELAY_LSB-1:0]};

  for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)                errFlags[f] <= 1'b0;
      else if (strobe.clrErr)   errFlags[f] <= 1'b0;
      else if (strobe.setFlag[f]) errFlags[f] <= 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrBank) begin
        dirtyBits[b] <= 1'b0;
        accBits[b]   <= 1'b0;
      end else begin
        if (strobe.setDirty[b]) dirtyBits[b] <= 1'b1;
        if (strobe.setAcc[b])   accBits[b]   <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               delayByte <= '0;
    else if (strobe.ldDelay) delayByte <= regWrData[DELAY_LSB +: DELAY_W];
  end

  always_comb begin
    regRdData = '0;
    if (regSel == SEL_ERR) begin
      regRdData[FLAG_W-1:0]                = errFlags;
      regRdData[DELAY_LSB +: DELAY_W]      = delayByte;
    end else begin
      regRdData[NUM_BANKS-1:0]             = accBits;
      regRdData[NUM_BANKS +: NUM_BANKS]    = dirtyBits;
    end
  end
endmodule

// File: rtl/memErrBankMon.sv
module memErrBankMon
  import memMonPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic [ADDR_W-1:0]    accAddr,
  input  logic [NUM_BANKS-1:0] bankPresent,
  input  logic                 ackErrPulse,
  input  logic                 refreshPulse,
  input  logic                 regWrEn,
  input  logic                 regSel,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData
);
  monStrobe_t           strobe;
  logic [FLAG_W-1:0]    errFlags;
  logic [NUM_BANKS-1:0] dirtyBits;
  logic [NUM_BANKS-1:0] accBits;

  memMonCtrl u_ctrl (
    .accValid     (accValid),
    .accWrite     (accWrite),
    .accAddr      (accAddr),
    .bankPresent  (bankPresent),
    .ackErrPulse  (ackErrPulse),
    .refreshPulse (refreshPulse),
    .regWrEn      (regWrEn),
    .regSel       (regSel),
    .strobe       (strobe)
  );

  memMonDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .errFlags  (errFlags),
    .dirtyBits (dirtyBits),
    .accBits   (accBits)
  );
endmodule

// File: rtl/memMonChecker.sv
module memMonChecker
  import memMonPkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic                 accWrite,
  input logic [ADDR_W-1:0]    accAddr,
  input logic [NUM_BANKS-1:0] bankPresent,
  input logic                 ackErrPulse,
  input logic                 refreshPulse,
  input logic                 regWrEn,
  input logic                 regSel,
  input logic [DATA_W-1:0]    regRdData,
  input logic [FLAG_W-1:0]    errFlags,
  input logic [NUM_BANKS-1:0] dirtyBits,
  input logic [NUM_BANKS-1:0] accBits
);
  logic errWr;
  logic bankWr;
  logic [BANK_IDX_W-1:0] chkIdx;
  assign errWr  = regWrEn && (regSel == SEL_ERR);
  assign bankWr = regWrEn && (regSel == SEL_BANK);
  assign chkIdx = accAddr[BANK_LSB +: BANK_IDX_W];

  p_err_layout_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_ERR) |-> (regRdData[31:16] == '0 && regRdData[7:3] == '0 && regRdData[2:0] == errFlags));

  p_ovr_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && !errWr && accAddr >= 32'h0080_0000 && accAddr <= 32'h03EF_FFFF) |=> errFlags[2]);

  p_nack_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !errWr && !bankPresent[chkIdx]) |=> errFlags[0]);

  p_ack_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackErrPulse && !errWr) |=> errFlags[1]);

  p_err_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    errWr |=> (errFlags == '0));

  p_bank_layout_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == SEL_BANK) |-> (regRdData == {16'h0, dirtyBits, accBits}));

  p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accWrite && bankPresent[chkIdx] && !bankWr && !refreshPulse) |=> dirtyBits[$past(chkIdx)]);

  p_refresh_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    refreshPulse |=> (dirtyBits == '0 && accBits == '0));

  p_bank_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    bankWr |=> (dirtyBits == '0 && accBits == '0));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !errWr |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  p_err_keep_r11: assert property (@(posedge clk) disable iff (!rstN)
    (bankWr || refreshPulse) |=> (errFlags & $past(errFlags)) == $past(errFlags));
endmodule

bind memErrBankMon memMonChecker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .accValid     (accValid),
  .accWrite     (accWrite),
  .accAddr      (accAddr),
  .bankPresent  (bankPresent),
  .ackErrPulse  (ackErrPulse),
  .refreshPulse (refreshPulse),
  .regWrEn      (regWrEn),
  .regSel       (regSel),
  .regRdData    (regRdData),
  .errFlags     (errFlags),
  .dirtyBits    (dirtyBits),
  .accBits      (accBits)
);

// File: tb/sim_memErrBankMon.sv
`timescale 1ns/1ps
module sim_memErrBankMon;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [31:0] accAddr = '0;
  logic [7:0]  bankPresent = '0;
  logic        ackErrPulse = 1'b0;
  logic        refreshPulse = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  always #5 clk = ~clk;

  memErrBankMon u0 (.*);

  typedef struct {
    logic [31:0] expVal;
    string       tag;
  } rdItem_t;

  rdItem_t scoreQ[$];
  logic    readReq = 1'b0;
  int      checks = 0;
  int      failures = 0;
  bit      done = 1'b0;

  // reference state, built from the requirements
  logic [2:0] mFlags = '0;
  logic [7:0] mDelay = '0;
  logic [7:0] mDirty = '0;
  logic [7:0] mAcc   = '0;

  task automatic step(input logic v, input logic w, input logic [31:0] a,
                      input logic ack, input logic rf, input logic wen,
                      input logic sel, input logic [31:0] d);
    logic [2:0] idx;
    logic hit, clrE, clrB;
    @(posedge clk); #1;
    accValid = v; accWrite = w; accAddr = a; ackErrPulse = ack;
    refreshPulse = rf; regWrEn = wen; regSel = sel; regWrData = d;
    idx  = a[22:20];
    hit  = bankPresent[idx];
    clrE = wen && !sel;
    clrB = rf || (wen && sel);
    if (clrE) begin
      mFlags = '0;
      mDelay = d[15:8];
    end else begin
      if (v && !w && a >= 32'h0080_0000 && a <= 32'h03EF_FFFF) mFlags[2] = 1'b1;
      if (v && !hit) mFlags[0] = 1'b1;
      if (ack) mFlags[1] = 1'b1;
    end
    if (clrB) begin
      mDirty = '0;
      mAcc   = '0;
    end else if (v && hit) begin
      if (w) mDirty[idx] = 1'b1;
      else   mAcc[idx]   = 1'b1;
    end
    @(posedge clk); #1;
    accValid = 1'b0; accWrite = 1'b0; ackErrPulse = 1'b0;
    refreshPulse = 1'b0; regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic access(input logic w, input logic [31:0] a);
    step(1'b1, w, a, 1'b0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic readReg(input logic sel, input string tag);
    rdItem_t it;
    it.tag = tag;
    it.expVal = sel ? {16'h0, mDirty, mAcc} : {16'h0, mDelay, 5'b0, mFlags};
    scoreQ.push_back(it);
    regSel  = sel;
    readReq = 1'b1;
    @(posedge clk); #1;
    readReq = 1'b0;
  endtask

  // monitor: compares the selected register against the queued expectation
  always @(negedge clk) begin
    if (readReq && scoreQ.size() > 0) begin
      rdItem_t it;
      it = scoreQ.pop_front();
      checks++;
      if (regRdData !== it.expVal) begin
        failures++;
        $display("FAIL %s: sel=%0d actual=%h expected=%h", it.tag, regSel, regRdData, it.expVal);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R12 / R1 / R6: reset contents
    readReg(1'b0, "R12_err_reset");
    readReg(1'b1, "R12_bank_reset");

    bankPresent = 8'h0F;
    // R7: read bank 0 sets its read bit
    access(1'b0, 32'h0000_0040);
    readReg(1'b1, "R7_read_bank0");
    // R7: write bank 3 sets its written bit
    access(1'b1, 32'h0030_0010);
    readReg(1'b1, "R7_write_bank3");
    readReg(1'b0, "R1_no_err_yet");
    // R3 / R7: absent bank 5 -> no-ack, no bank bit
    access(1'b0, 32'h0050_0000);
    readReg(1'b0, "R3_nack_read");
    readReg(1'b1, "R7_absent_untouched");
    // R5: clearing write loads delay and clears flags
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFF_3CFF);
    readReg(1'b0, "R5_err_clear");
    // R3: write to absent bank 6
    access(1'b1, 32'h0060_0000);
    readReg(1'b0, "R3_nack_write");

    // R2: window boundaries, all banks present
    bankPresent = 8'hFF;
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_1100);
    access(1'b0, 32'h007F_FFFF);
    readReg(1'b0, "R2_below_window");
    access(1'b0, 32'h0080_0000);
    readReg(1'b0, "R2_low_edge");
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_2200);
    access(1'b1, 32'h0100_0000);
    readReg(1'b0, "R2_write_in_window");
    access(1'b0, 32'h03F0_0000);
    readReg(1'b0, "R2_above_window");
    access(1'b0, 32'h03EF_FFFF);
    readReg(1'b0, "R2_high_edge");
    // R2 with absent bank: both flags
    bankPresent = 8'hFE;
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000);
    access(1'b0, 32'h0200_0000);
    readReg(1'b0, "R2_R3_absent_in_window");

    // R4 / R10: ack pulse adds to sticky flags
    step(1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    readReg(1'b0, "R4_ack_pulse");
    repeat (3) @(posedge clk);
    readReg(1'b0, "R10_sticky");

    // R8: refresh clears bank bits, not errors
    bankPresent = 8'hFF;
    access(1'b1, 32'h0070_0000);
    access(1'b0, 32'h0020_0000);
    readReg(1'b1, "R7_bank_bits_before_refresh");
    step(1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    readReg(1'b1, "R8_refresh_clears");
    readReg(1'b0, "R8_err_kept");

    // R9: bank write clears, error and delay kept
    access(1'b1, 32'h0010_0000);
    step(1'b0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hDEAD_BEEF);
    readReg(1'b1, "R9_bank_clear");
    readReg(1'b0, "R9_err_kept");

    // R11: event with error clear -> errors dropped, bank bit kept
    step(1'b1, 1'b0, 32'h0040_0000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_5A00);
    readReg(1'b0, "R11_err_clear_wins");
    readReg(1'b1, "R11_bank_still_set");
    // R11: write with refresh -> bank bit dropped, nack from absent bank kept
    bankPresent = 8'hF7;
    access(1'b1, 32'h0050_0000);
    step(1'b1, 1'b1, 32'h0030_0000, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    readReg(1'b1, "R11_refresh_wins");
    readReg(1'b0, "R11_err_event_kept");
    // R11: read with bank-status write -> bank bit dropped
    step(1'b1, 1'b0, 32'h0020_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0000);
    readReg(1'b1, "R11_bank_wr_wins");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule